// File: doc/BRIEF.md
# Four-Channel DMA Control and Status Register Block

This block holds the control state of a four-channel DMA engine and decodes the byte writes and reads sent to its eight control ports. It keeps a command register, a per-channel mask, a per-channel request bit, a per-channel terminal-count flag and a per-channel mode byte. It also keeps the low/high byte pointer that a neighbouring address/count register block uses.

Every cycle it looks at all four channels in index order 0 to 3. Each channel that is unmasked and has a pending request is granted service in the following cycle. While a channel is granted, the transfer engine raises that channel's completion input when the channel's progress reaches its base count plus one. The block then sets the channel's terminal-count flag. Requests come from software through the request port, or from hardware as a level input whose edges set and clear the request bit.

Top module: `dma_ctl_regs`

## Requirements
- R1: A write to port 0 loads the command register only when the byte is 8'h00 or 8'h04 (bit 2 alone). Any other byte leaves `cmd_out` unchanged.
- R2: A write to port 1 selects channel `wr_data[1:0]`. It sets that channel's request bit when `wr_data[2]`=1 and clears it when `wr_data[2]`=0. It also clears that channel's terminal-count flag.
- R3: A write to port 2 selects channel `wr_data[1:0]`. It sets that channel's mask bit when `wr_data[2]`=1 and clears it when `wr_data[2]`=0. The other mask bits keep their values.
- R4: A write to port 3 stores the whole byte as the mode of channel `wr_data[1:0]`. The mode appears on `mode_out[8*ch+7:8*ch]`. In that byte, [3:2] is the transfer type, bit 4 is auto-initialise, bit 5 is address decrement and [7:6] is the operating mode. The other channels' modes are unchanged.
- R5: A write to port 5 is a master reset. It sets all mask bits and clears all request bits, all terminal-count flags, the command register, the byte pointer and the grants. Mode bytes are kept.
- R6: A write to port 6 clears every mask bit. A write to port 7 loads mask bit i from `wr_data[i]`. A write to port 4 clears the byte pointer. A `ptr_toggle` pulse inverts the byte pointer, and a clear in the same cycle wins over the toggle.
- R7: `rd_data` is registered and valid the cycle after `rd_en`. A read of port 0 returns the status byte: request bits in [7:4] and terminal-count flags in [3:0], with channel i at bit 4+i and bit i. The flags are cleared after the read. A read of port 1 returns the mask in [3:0] with zeros in [7:4]. Ports 2 to 7 read 8'h00.
- R8: `grant[i]` is 1 in the cycle after the cycle in which channel i has mask 0 and request 1, and 0 otherwise.
- R9: When `grant[i]` and `chan_done[i]` are both 1, the terminal-count flag of channel i is set at that edge. The flag stays set until a port 0 read, a port 1 write to that channel, or a master reset clears it. A set in the same cycle as a status read wins.
- R10: A rising edge on `hw_req[i]` sets request bit i and a falling edge clears it. A steady level changes nothing. A port 1 write to the same channel in the same cycle wins over the edge.
- R11: After the synchronous reset `rst`, the mask is 4'hF and the request bits, terminal-count flags, command, modes, grants, byte pointer and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control port write strobe |
| rd_en | input | 1 | Control port read strobe |
| port_sel | input | 3 | Control port number 0..7 |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| hw_req | input | 4 | Hardware request levels, one per channel |
| chan_done | input | 4 | Per-channel completion (progress reached base count plus one) |
| ptr_toggle | input | 1 | Byte-pointer toggle from the address/count register block |
| grant | output | 4 | Registered per-channel service grant |
| cmd_out | output | 8 | Command register |
| mode_out | output | 32 | Four mode bytes, channel i in bits [8i+7:8i] |
| byte_ptr | output | 1 | Low/high byte pointer |

## Verification
The assertions check these rules on every cycle:
- a rejected command byte never reaches `cmd_out`, and the command value is always legal;
- a master reset leaves the expected state one cycle later;
- a status read with no simultaneous completion empties the terminal-count flags;
- no grant follows a cycle in which that channel was masked;
- a granted completion always leaves its flag set;
- a port 4 write always clears the byte pointer.

Some behaviours can only be shown by the bench's scenarios, because they need the exact read values of particular sequences:
- the status and mask read values after a sequence of writes;
- the one-cycle grant latency after an unmask;
- per-channel placement of mode bytes;
- the ordering when a hardware edge and a software request, or a completion and a status read, land in the same cycle.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

  typedef enum logic [2:0] {
    P_CMD_STAT = 3'd0,
    P_REQ      = 3'd1,
    P_SMASK    = 3'd2,
    P_MODE     = 3'd3,
    P_PTR_CLR  = 3'd4,
    P_MRST     = 3'd5,
    P_MCLR     = 3'd6,
    P_MLOAD    = 3'd7
  } ctl_port_e;

  localparam logic [7:0] CMD_BLOCK_BIT = 8'h04;

  // A command byte is taken only when it enables no unsupported feature.
  function automatic logic cmd_legal(input logic [7:0] b);
    return (b == 8'h00) || (b == CMD_BLOCK_BIT);
  endfunction

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic          wr_en,
  input  logic [2:0]    port_sel,
  input  logic [DW-1:0] wr_data,
  output logic          cmd_ld,
  output logic          req_wr,
  output logic          smask_wr,
  output logic          mode_wr,
  output logic          ptr_clr,
  output logic          mrst,
  output logic          mask_ld,
  output logic [NCH-1:0] mask_ld_val
);
  ctl_port_e p;
  assign p = ctl_port_e'(port_sel);

  always_comb begin
    cmd_ld      = wr_en && (p == P_CMD_STAT) && cmd_legal(wr_data[7:0]);
    req_wr      = wr_en && (p == P_REQ);
    smask_wr    = wr_en && (p == P_SMASK);
    mode_wr     = wr_en && (p == P_MODE);
    mrst        = wr_en && (p == P_MRST);
    ptr_clr     = wr_en && ((p == P_PTR_CLR) || (p == P_MRST));
    mask_ld     = wr_en && ((p == P_MCLR) || (p == P_MLOAD));
    mask_ld_val = (p == P_MLOAD) ? wr_data[NCH-1:0] : '0;
  end
endmodule

// File: rtl/dma_ctl_chan.sv
module dma_ctl_chan #(
  parameter int DW   = 8,
  parameter int CSEL = 2,
  parameter int IDX  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] wr_data,
  input  logic          req_wr,
  input  logic          smask_wr,
  input  logic          mode_wr,
  input  logic          mrst,
  input  logic          mask_ld,
  input  logic          mask_ld_bit,
  input  logic          tc_rd_clr,
  input  logic          hw_req,
  input  logic          done,
  output logic          mask_q,
  output logic          req_q,
  output logic          tc_q,
  output logic          grant_q,
  output logic [DW-1:0] mode_q
);
  logic hit, hw_prev_q, hw_rise, hw_fall, set_bit;

  assign hit     = (wr_data[CSEL-1:0] == CSEL'(IDX));
  assign set_bit = wr_data[CSEL];
  assign hw_rise = hw_req & ~hw_prev_q;
  assign hw_fall = ~hw_req & hw_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_prev_q <= 1'b0;
      mask_q    <= 1'b1;
      req_q     <= 1'b0;
      tc_q      <= 1'b0;
      grant_q   <= 1'b0;
      mode_q    <= '0;
    end else begin
      hw_prev_q <= hw_req;
      if (mode_wr && hit) mode_q <= wr_data;

      if (mrst)                 mask_q <= 1'b1;
      else if (mask_ld)         mask_q <= mask_ld_bit;
      else if (smask_wr && hit) mask_q <= set_bit;

      // software request write has priority over a hardware edge
      if (mrst)               req_q <= 1'b0;
      else if (req_wr && hit) req_q <= set_bit;
      else if (hw_rise)       req_q <= 1'b1;
      else if (hw_fall)       req_q <= 1'b0;

      // completion set wins over read clear
      if (mrst)                                tc_q <= 1'b0;
      else if (grant_q && done)                tc_q <= 1'b1;
      else if ((req_wr && hit) || tc_rd_clr)   tc_q <= 1'b0;

      if (mrst) grant_q <= 1'b0;
      else      grant_q <= ~mask_q & req_q;
    end
  end
endmodule

// File: rtl/dma_ctl_rdmux.sv
module dma_ctl_rdmux
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_en,
  input  logic [2:0]     port_sel,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] tc,
  input  logic [NCH-1:0] mask,
  output logic           stat_rd,
  output logic [DW-1:0]  rd_data_q
);
  localparam int PAD = DW - NCH;
  logic [DW-1:0] rd_val;

  assign stat_rd = rd_en && (ctl_port_e'(port_sel) == P_CMD_STAT);

  always_comb begin
    unique case (ctl_port_e'(port_sel))
      P_CMD_STAT: rd_val = DW'({req, tc});
      P_REQ:      rd_val = {{PAD{1'b0}}, mask};
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data_q <= '0;
    else if (rd_en) rd_data_q <= rd_val;
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        port_sel,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [NCH-1:0]    hw_req,
  input  logic [NCH-1:0]    chan_done,
  input  logic              ptr_toggle,
  output logic [NCH-1:0]    grant,
  output logic [DW-1:0]     cmd_out,
  output logic [NCH*DW-1:0] mode_out,
  output logic              byte_ptr
);
  localparam int CSEL = $clog2(NCH);

  logic cmd_ld, req_wr, smask_wr, mode_wr, ptr_clr, mrst, mask_ld, stat_rd;
  logic [NCH-1:0] mask_ld_val, mask_v, req_v, tc_v;
  logic [DW-1:0]  cmd_q;
  logic           ptr_q;

  dma_ctl_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data),
    .cmd_ld(cmd_ld), .req_wr(req_wr), .smask_wr(smask_wr), .mode_wr(mode_wr),
    .ptr_clr(ptr_clr), .mrst(mrst), .mask_ld(mask_ld), .mask_ld_val(mask_ld_val)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_ctl_chan #(.DW(DW), .CSEL(CSEL), .IDX(i)) u_ch (
      .clk(clk), .rst(rst), .wr_data(wr_data),
      .req_wr(req_wr), .smask_wr(smask_wr), .mode_wr(mode_wr), .mrst(mrst),
      .mask_ld(mask_ld), .mask_ld_bit(mask_ld_val[i]), .tc_rd_clr(stat_rd),
      .hw_req(hw_req[i]), .done(chan_done[i]),
      .mask_q(mask_v[i]), .req_q(req_v[i]), .tc_q(tc_v[i]),
      .grant_q(grant[i]), .mode_q(mode_out[i*DW +: DW])
    );
  end

  dma_ctl_rdmux #(.NCH(NCH), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .port_sel(port_sel),
    .req(req_v), .tc(tc_v), .mask(mask_v),
    .stat_rd(stat_rd), .rd_data_q(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst || mrst)  cmd_q <= '0;
    else if (cmd_ld)  cmd_q <= wr_data;

    if (rst || ptr_clr)  ptr_q <= 1'b0;
    else if (ptr_toggle) ptr_q <= ~ptr_q;
  end

  assign cmd_out  = cmd_q;
  assign byte_ptr = ptr_q;
endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic           rd_en,
  input logic [2:0]     port_sel,
  input logic [DW-1:0]  wr_data,
  input logic [DW-1:0]  cmd,
  input logic [NCH-1:0] mask,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] tc,
  input logic [NCH-1:0] grant,
  input logic [NCH-1:0] done,
  input logic           byte_ptr
);
  logic bad_cmd_wr, mrst_wr;
  assign bad_cmd_wr = wr_en && port_sel == 3'd0 && !(wr_data == 8'h00 || wr_data == 8'h04);
  assign mrst_wr    = wr_en && port_sel == 3'd5;

  p_cmd_reject_r1: assert property (@(posedge clk) disable iff (rst)
    bad_cmd_wr |=> $stable(cmd));
  p_cmd_legal_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd == 8'h00 || cmd == 8'h04));
  p_mrst_state_r5: assert property (@(posedge clk) disable iff (rst)
    mrst_wr |=> (mask == '1 && req == '0 && tc == '0 && cmd == '0 && !byte_ptr));
  p_stat_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && port_sel == 3'd0 && (grant & done) == '0) |=> tc == '0);
  p_grant_unmasked_r8: assert property (@(posedge clk) disable iff (rst)
    (grant & $past(mask)) == '0);
  p_tc_set_r9: assert property (@(posedge clk) disable iff (rst)
    ((grant & done) != '0 && !mrst_wr) |=> ((tc & $past(grant & done)) == $past(grant & done)));
  p_ptr_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_sel == 3'd4) |=> !byte_ptr);
endmodule

bind dma_ctl_regs dma_ctl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
  .wr_data(wr_data), .cmd(cmd_q), .mask(mask_v), .req(req_v), .tc(tc_v),
  .grant(grant), .done(chan_done), .byte_ptr(ptr_q)
);

// File: tb/tb_dma_ctl_regs.sv
`timescale 1ns/1ps
module tb_dma_ctl_regs;
  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, ptr_toggle = 0;
  logic [2:0] port_sel = 0;
  logic [7:0] wr_data = 0, rd_data, cmd_out;
  logic [3:0] hw_req = 0, chan_done = 0, grant;
  logic [31:0] mode_out;
  logic byte_ptr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_ctl_regs dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .port_sel(port_sel), .wr_data(wr_data), .rd_data(rd_data), .hw_req(hw_req),
    .chan_done(chan_done), .ptr_toggle(ptr_toggle), .grant(grant),
    .cmd_out(cmd_out), .mode_out(mode_out), .byte_ptr(byte_ptr));

  // {is_read, port, data, expected read}
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1,3'd1,8'h00,8'h0F}, {1'b0,3'd6,8'h00,8'h00}, {1'b1,3'd1,8'h00,8'h00},
    {1'b0,3'd7,8'h0A,8'h00}, {1'b1,3'd1,8'h00,8'h0A}, {1'b0,3'd2,8'h04,8'h00},
    {1'b1,3'd1,8'h00,8'h0B}, {1'b0,3'd2,8'h01,8'h00}, {1'b1,3'd1,8'h00,8'h09},
    {1'b0,3'd1,8'h06,8'h00}, {1'b1,3'd0,8'h00,8'h40}, {1'b0,3'd1,8'h07,8'h00},
    {1'b1,3'd0,8'h00,8'hC0}, {1'b0,3'd1,8'h02,8'h00}, {1'b1,3'd0,8'h00,8'h80},
    {1'b1,3'd2,8'h00,8'h00}, {1'b1,3'd7,8'h00,8'h00}, {1'b0,3'd5,8'h00,8'h00},
    {1'b1,3'd0,8'h00,8'h00}, {1'b1,3'd1,8'h00,8'h0F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] p, input logic [7:0] d);
    @(negedge clk); wr_en = 1; port_sel = p; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] p, input string req, input logic [7:0] exp);
    @(negedge clk); rd_en = 1; port_sel = p;
    @(negedge clk); rd_en = 0;
    check(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check("R11 grant", {28'h0, grant}, 0);
    check("R11 cmd", {24'h0, cmd_out}, 0);
    check("R11 mode", mode_out, 0);
    check("R11 ptr/rd", {23'h0, byte_ptr, rd_data}, 0);

    // table of register writes and reads (R3 R6 R7 R2 R5)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) rd(VEC[i][18:16], $sformatf("R7 table row %0d", i), VEC[i][7:0]);
      else            wr(VEC[i][18:16], VEC[i][15:8]);
    end

    // R1 command acceptance
    wr(0, 8'h04); check("R1 accept 04", {24'h0, cmd_out}, 32'h04);
    wr(0, 8'h01); check("R1 reject 01", {24'h0, cmd_out}, 32'h04);
    wr(0, 8'h0C); check("R1 reject 0C", {24'h0, cmd_out}, 32'h04);
    wr(0, 8'h00); check("R1 accept 00", {24'h0, cmd_out}, 32'h00);

    // R4 mode bytes
    wr(3, 8'h96); check("R4 mode ch2", mode_out, 32'h0096_0000);
    wr(3, 8'h5B); check("R4 mode ch3", mode_out, 32'h5B96_0000);

    // R6 byte pointer
    @(negedge clk); ptr_toggle = 1; @(negedge clk); ptr_toggle = 0;
    check("R6 toggle", {31'h0, byte_ptr}, 1);
    wr(4, 8'h00); check("R6 port4 clear", {31'h0, byte_ptr}, 0);
    @(negedge clk); ptr_toggle = 1; wr_en = 1; port_sel = 4;
    @(negedge clk); ptr_toggle = 0; wr_en = 0;
    check("R6 clear beats toggle", {31'h0, byte_ptr}, 0);

    // R8 grant timing
    wr(6, 8'h00); wr(1, 8'h05);
    check("R8 grant not yet", {28'h0, grant}, 0);
    @(negedge clk); check("R8 grant ch1", {28'h0, grant}, 32'h2);
    wr(2, 8'h05); check("R8 grant held one cycle", {28'h0, grant}, 32'h2);
    @(negedge clk); check("R8 grant drops on mask", {28'h0, grant}, 0);
    wr(2, 8'h01); @(negedge clk);
    check("R8 grant back", {28'h0, grant}, 32'h2);

    // R9 terminal count set, R7 read clear
    chan_done = 4'h2; @(negedge clk); chan_done = 0;
    rd(0, "R9 tc set", 8'h22);
    rd(0, "R7 tc cleared by read", 8'h20);
    @(negedge clk); chan_done = 4'h2; rd_en = 1; port_sel = 0;
    @(negedge clk); chan_done = 0; rd_en = 0;
    check("R9 read same cycle returns old", {24'h0, rd_data}, 32'h20);
    rd(0, "R9 set beats read clear", 8'h22);
    wr(1, 8'h01);
    rd(0, "R2 request clear drops tc", 8'h00);

    // R10 hardware request edges
    @(negedge clk); hw_req[0] = 1; @(negedge clk);
    rd(0, "R10 rising edge", 8'h10);
    rd(0, "R10 steady level", 8'h10);
    @(negedge clk); hw_req[0] = 0; @(negedge clk);
    rd(0, "R10 falling edge", 8'h00);
    @(negedge clk); hw_req[3] = 1; wr_en = 1; port_sel = 1; wr_data = 8'h03;
    @(negedge clk); wr_en = 0;
    rd(0, "R10 sw clear beats hw rise", 8'h00);
    @(negedge clk); hw_req[3] = 0; wr_en = 1; port_sel = 1; wr_data = 8'h07;
    @(negedge clk); wr_en = 0;
    rd(0, "R10 sw set beats hw fall", 8'h80);

    // R5 master reset keeps modes
    wr(5, 8'h00);
    check("R5 modes kept", mode_out, 32'h5B96_0000);
    rd(1, "R5 mask all set", 8'h0F);
    rd(0, "R5 status zero", 8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule